// File: doc/BRIEF.md
# Paged flash programming sequencer

This block sits on the host side of a serial programming link and turns a flash image into a stream of four-byte programming instructions. It fetches the image one byte at a time from a data source, issues a page-load instruction for each byte carrying only the in-page part of the byte address with the data, and after the last byte of a page issues a page-commit instruction carrying the page number. After every commit it keeps the link completely silent for the flash write time. Only then does it move on to the next page. An image whose length is not a multiple of the page size still has its last partial page committed.

A separate erase command issues a chip-erase instruction. The block then waits twice the flash write time with the serial clock parked low. It drives a target reset pulse of a configurable number of cycles and finally raises a one-cycle request for the serial layer to re-establish synchronisation. The serial shifter and the sync handshake are not part of this block. Every instruction is offered on a request/complete pair, and its fields are held steady until the complete strobe arrives.

Top module: `flash_page_sequencer`

## Requirements
- R1: After reset, busy_o, ins_req_o, tgt_reset_o, sck_idle_o and sync_req_o are all low.
- R2: For each image byte at address a, a load instruction is requested with ins_kind_o = 0. ins_addr_o holds a mod 2^PAGE_BITS in its low bits with all upper bits zero, ins_data_o holds the source byte and src_addr_o equals a.
- R3: After the load of a byte whose low PAGE_BITS address bits are all ones, a commit instruction follows with ins_kind_o = 1 and ins_addr_o = a >> PAGE_BITS.
- R4: After the load of the image's last byte, a commit for that byte's page follows even when the page is only partly filled.
- R5: After each commit completes, ins_req_o stays low for exactly WRITE_WAIT cycles before the next request.
- R6: Bytes are loaded in ascending address order from 0. Within a page, each next load is requested in the cycle right after the previous one completes.
- R7: busy_o rises the cycle after an accepted start and falls exactly WRITE_WAIT cycles after the final commit completes.
- R8: A start with img_len_i equal to zero is ignored and the block stays idle.
- R9: On erase, an instruction with ins_kind_o = 2 is requested. After it completes, there are 2*WRITE_WAIT cycles with no request, tgt_reset_o low and sck_idle_o high. Then tgt_reset_o is high for RST_CYC cycles with sck_idle_o high and no request.
- R10: In the cycle after the reset pulse ends, sync_req_o is high for one cycle and the block then returns to idle.
- R11: While ins_req_o is high and ins_done_i is low, the request and all its fields stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start programming the image |
| erase_i | input | 1 | Start a chip-erase sequence (wins over start) |
| img_len_i | input | ADDR_W+1 | Image length in bytes, sampled at start |
| src_addr_o | output | ADDR_W | Byte address requested from the data source |
| src_data_i | input | 8 | Source byte at src_addr_o |
| ins_req_o | output | 1 | Instruction request |
| ins_kind_o | output | 2 | 0 load, 1 commit, 2 erase |
| ins_addr_o | output | ADDR_W | Address field of the instruction |
| ins_data_o | output | 8 | Data field of the instruction |
| ins_done_i | input | 1 | Instruction-complete strobe |
| tgt_reset_o | output | 1 | Target reset line |
| sck_idle_o | output | 1 | Serial clock must be parked low |
| sync_req_o | output | 1 | One-cycle request to re-sync the link |
| busy_o | output | 1 | Sequence in progress |

## Verification
On every cycle the assertions check that requests hold their fields until completion and that a load field never leaks page bits. They also check that no request appears during a post-commit quiet window, during the reset pulse or while idle, and that the sync pulse directly follows the reset pulse and lasts one cycle. The exact load and commit sequence for each image length, the partial-page commit, the lengths of the erase wait and reset pulse, the ignored zero-length start and the end of busy can only be shown by the bench scenarios. The bench compares these against instruction lists and cycle counts that it computes itself.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    INS_LOAD   = 2'd0,
    INS_COMMIT = 2'd1,
    INS_ERASE  = 2'd2
  } ins_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMMIT,
    ST_PGWAIT,
    ST_ERASE,
    ST_ERWAIT,
    ST_RSTP,
    ST_SYNC
  } seq_state_t;
endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (en_i && cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/flash_seq_addr_ctr.sv
module flash_seq_addr_ctr #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BITS = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic [ADDR_W:0] len_i,
  input  logic            inc_i,
  output logic [ADDR_W:0] addr_o,
  output logic            page_end_o,
  output logic            last_o,
  output logic            at_end_o
);
  logic [ADDR_W:0] addr_q, addr_d, len_q, len_d;

  always_comb begin
    addr_d = addr_q;
    len_d  = len_q;
    if (clear_i) begin
      addr_d = '0;
      len_d  = len_i;
    end else if (inc_i) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      addr_q <= addr_d;
      len_q  <= len_d;
    end
  end

  assign addr_o     = addr_q;
  assign page_end_o = &addr_q[PAGE_BITS-1:0];
  assign last_o     = ((addr_q + 1'b1) == len_q);
  assign at_end_o   = (addr_q == len_q);
endmodule

// File: rtl/flash_page_sequencer.sv
module flash_page_sequencer
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BITS  = 7,
  parameter int WRITE_WAIT = 1000,
  parameter int RST_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic [ADDR_W:0]   img_len_i,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic [7:0]        src_data_i,
  output logic              ins_req_o,
  output logic [1:0]        ins_kind_o,
  output logic [ADDR_W-1:0] ins_addr_o,
  output logic [7:0]        ins_data_o,
  input  logic              ins_done_i,
  output logic              tgt_reset_o,
  output logic              sck_idle_o,
  output logic              sync_req_o,
  output logic              busy_o
);
  localparam int LONGEST = (2 * WRITE_WAIT > RST_CYC) ? 2 * WRITE_WAIT : RST_CYC;
  localparam int CNT_W   = $clog2(LONGEST) + 1;
  localparam logic [CNT_W-1:0] PG_LOAD  = CNT_W'(WRITE_WAIT - 1);
  localparam logic [CNT_W-1:0] ER_LOAD  = CNT_W'(2 * WRITE_WAIT - 1);
  localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_t      state_q, state_d;
  logic            tmr_load, tmr_en, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic            ctr_clear, ctr_inc;
  logic            page_end, last_byte, at_end;
  logic [ADDR_W:0] addr;

  flash_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .en_i       (tmr_en),
    .zero_o     (tmr_zero)
  );

  flash_seq_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_addr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clear_i    (ctr_clear),
    .len_i      (img_len_i),
    .inc_i      (ctr_inc),
    .addr_o     (addr),
    .page_end_o (page_end),
    .last_o     (last_byte),
    .at_end_o   (at_end)
  );

  // next-state and control
  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = PG_LOAD;
    tmr_en    = 1'b0;
    ctr_clear = 1'b0;
    ctr_inc   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (erase_i) begin
          state_d = ST_ERASE;
        end else if (start_i && img_len_i != '0) begin
          state_d   = ST_LOAD;
          ctr_clear = 1'b1;
        end
      end
      ST_LOAD: begin
        if (ins_done_i) begin
          if (page_end || last_byte) state_d = ST_COMMIT;
          else                       ctr_inc = 1'b1;
        end
      end
      ST_COMMIT: begin
        if (ins_done_i) begin
          state_d  = ST_PGWAIT;
          ctr_inc  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = PG_LOAD;
        end
      end
      ST_PGWAIT: begin
        tmr_en = 1'b1;
        if (tmr_zero) state_d = at_end ? ST_IDLE : ST_LOAD;
      end
      ST_ERASE: begin
        if (ins_done_i) begin
          state_d  = ST_ERWAIT;
          tmr_load = 1'b1;
          tmr_val  = ER_LOAD;
        end
      end
      ST_ERWAIT: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          state_d  = ST_RSTP;
          tmr_load = 1'b1;
          tmr_val  = RST_LOAD;
        end
      end
      ST_RSTP: begin
        tmr_en = 1'b1;
        if (tmr_zero) state_d = ST_SYNC;
      end
      ST_SYNC: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  // instruction fields
  always_comb begin
    ins_req_o  = 1'b0;
    ins_kind_o = INS_LOAD;
    ins_addr_o = '0;
    ins_data_o = '0;
    unique case (state_q)
      ST_LOAD: begin
        ins_req_o  = 1'b1;
        ins_kind_o = INS_LOAD;
        ins_addr_o = ADDR_W'(addr[PAGE_BITS-1:0]);
        ins_data_o = src_data_i;
      end
      ST_COMMIT: begin
        ins_req_o  = 1'b1;
        ins_kind_o = INS_COMMIT;
        ins_addr_o = ADDR_W'(addr[ADDR_W-1:PAGE_BITS]);
      end
      ST_ERASE: begin
        ins_req_o  = 1'b1;
        ins_kind_o = INS_ERASE;
      end
      default: ;
    endcase
  end

  assign src_addr_o  = addr[ADDR_W-1:0];
  assign tgt_reset_o = (state_q == ST_RSTP);
  assign sck_idle_o  = (state_q == ST_ERWAIT) || (state_q == ST_RSTP);
  assign sync_req_o  = (state_q == ST_SYNC);
  assign busy_o      = (state_q != ST_IDLE);
endmodule

// File: rtl/flash_page_seq_checker.sv
module flash_page_seq_checker #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BITS  = 7,
  parameter int WRITE_WAIT = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_req_o,
  input logic [1:0]        ins_kind_o,
  input logic [ADDR_W-1:0] ins_addr_o,
  input logic [7:0]        ins_data_o,
  input logic              ins_done_i,
  input logic              tgt_reset_o,
  input logic              sck_idle_o,
  input logic              sync_req_o,
  input logic              busy_o
);
  localparam int QW = $clog2(WRITE_WAIT + 1) + 1;
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      quiet_q <= '0;
    else if (ins_req_o && ins_done_i && ins_kind_o == 2'd1)
      quiet_q <= QW'(WRITE_WAIT);
    else if (quiet_q != '0)
      quiet_q <= quiet_q - 1'b1;
  end

  AST_QUIET_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q != '0) |-> !ins_req_o); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req_o && !ins_done_i) |=> (ins_req_o && $stable(ins_kind_o) &&
      $stable(ins_addr_o) && $stable(ins_data_o))); // R11
  AST_LOAD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req_o && ins_kind_o == 2'd0) |-> ((ins_addr_o >> PAGE_BITS) == '0)); // R2
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_reset_o |-> (!ins_req_o && sck_idle_o)); // R9
  AST_SYNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_reset_o) |-> sync_req_o); // R10
  AST_SYNC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req_o |=> !sync_req_o); // R10
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!ins_req_o && !tgt_reset_o && !sync_req_o)); // R1
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req_o |-> busy_o); // R7
endmodule

bind flash_page_sequencer flash_page_seq_checker #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .WRITE_WAIT(WRITE_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_req_o(ins_req_o), .ins_kind_o(ins_kind_o),
  .ins_addr_o(ins_addr_o), .ins_data_o(ins_data_o), .ins_done_i(ins_done_i),
  .tgt_reset_o(tgt_reset_o), .sck_idle_o(sck_idle_o),
  .sync_req_o(sync_req_o), .busy_o(busy_o)
);

// File: tb/flash_page_sequencer_test.sv
module flash_page_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int PB  = 2;
  localparam int WW  = 5;
  localparam int RC  = 3;
  localparam int LAT = 1;

  logic          clk, rst_n, start, erase, done;
  logic [AW:0]   img_len;
  logic [AW-1:0] src_addr, ins_addr;
  logic [7:0]    src_data, ins_data;
  logic          ins_req, tgt_reset, sck_idle, sync_req, busy;
  logic [1:0]    ins_kind;

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] dat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  assign src_data = dat(int'(src_addr));

  flash_page_sequencer #(.ADDR_W(AW), .PAGE_BITS(PB), .WRITE_WAIT(WW), .RST_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .erase_i(erase), .img_len_i(img_len),
    .src_addr_o(src_addr), .src_data_i(src_data), .ins_req_o(ins_req),
    .ins_kind_o(ins_kind), .ins_addr_o(ins_addr), .ins_data_o(ins_data),
    .ins_done_i(done), .tgt_reset_o(tgt_reset), .sck_idle_o(sck_idle),
    .sync_req_o(sync_req), .busy_o(busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait for a request, measure the idle gap, check fields, complete it
  task automatic expect_ins(int kind, int addr, int data, int sa, int gap, string req);
    int g = 0;
    while (!ins_req && g < 1000) begin
      g++;
      @(negedge clk);
    end
    check(g == gap, {req, " gap"}, g, gap);
    check(int'(ins_kind) == kind, {req, " kind"}, int'(ins_kind), kind);
    check(int'(ins_addr) == addr, {req, " addr"}, int'(ins_addr), addr);
    if (kind == 0) begin
      check(int'(ins_data) == data, "R2 data", int'(ins_data), data);
      check(int'(src_addr) == sa, "R6 order", int'(src_addr), sa);
    end
    repeat (LAT) @(negedge clk);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic run_image(int len);
    int g = 0;
    int gap_next = 0;
    img_len = (AW + 1)'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy on start", int'(busy), 1);
    for (int i = 0; i < len; i++) begin
      expect_ins(0, i % (1 << PB), int'(dat(i)), i, gap_next,
                 (gap_next == 0) ? "R6 load" : "R5 load after wait");
      if ((i % (1 << PB)) == (1 << PB) - 1 || i == len - 1) begin
        expect_ins(1, i >> PB, 0, 0, 0, (i == len - 1) ? "R4 commit" : "R3 commit");
        gap_next = WW;
      end else begin
        gap_next = 0;
      end
    end
    while (busy && g < 1000) begin
      if (ins_req) check(1'b0, "R5 quiet", 1, 0);
      g++;
      @(negedge clk);
    end
    check(g == WW, "R7 busy end", g, WW);
  endtask

  task automatic run_erase();
    int g = 0;
    int bad = 0;
    erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    expect_ins(2, 0, 0, 0, 0, "R9 erase");
    while (!tgt_reset && g < 1000) begin
      if (ins_req || !sck_idle) bad++;
      g++;
      @(negedge clk);
    end
    check(g == 2 * WW, "R9 erase wait", g, 2 * WW);
    check(bad == 0, "R9 wait quiet", bad, 0);
    g = 0;
    while (tgt_reset && g < 1000) begin
      if (ins_req || !sck_idle) bad++;
      g++;
      @(negedge clk);
    end
    check(g == RC, "R9 reset width", g, RC);
    check(bad == 0, "R9 pulse quiet", bad, 0);
    check(sync_req == 1'b1, "R10 sync", int'(sync_req), 1);
    @(negedge clk);
    check(sync_req == 1'b0, "R10 sync one cycle", int'(sync_req), 0);
    check(busy == 1'b0, "R10 back to idle", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; erase = 1'b0; done = 1'b0; img_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !ins_req && !tgt_reset && !sck_idle && !sync_req, "R1 reset state",
          int'({busy, ins_req, tgt_reset, sck_idle, sync_req}), 0);
    // zero-length start
    img_len = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R8 zero length", int'(busy), 0);
    check(ins_req == 1'b0, "R8 no request", int'(ins_req), 0);
    // sweep image lengths across partial and full pages
    for (int len = 1; len <= 13; len++) begin
      run_image(len);
      @(negedge clk);
    end
    run_erase();
    @(negedge clk);
    run_image(6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule